// File: doc/BRIEF.md
# Segment Drive Level Selector with Two-Line Latch

This block sits behind the column data loader of a passive-matrix segment driver. Each line period, the loader presents a complete line of display bits on `line_data`. When the line pulse falls, the block latches that line. It also keeps the line that was latched one period earlier. A second pair of stages follows the frame alternation input. The first stage is loaded when the line pulse rises. The second stage is loaded when the line pulse falls, so it always holds the alternation state of the line being driven.

From these stored values and the live control inputs, the block gives every segment output a 3-bit level code for the analog switch bank that follows it. There are five levels. Outside a compensation window, each output gets the high or the low level, after polarity inversion by the alternation input. Inside a window, an output whose effective polarity has changed since the previous line is pushed one step further, to the high or low compensation level, in the direction it is moving. This offsets the slow edges on the panel. A display-enable input forces every output to the mid level, which blanks the panel.

The line pulse is an ordinary synchronous input. Its edges are found by sampling it on `clk`.

Top module: `seg_level_drive`

## Requirements
- R1: After reset, both line latches and both alternation stages hold 0. With `disp_on` high and `alt_in`, `win_a` and `win_b` low, every output then reads code 1.
- R2: A falling edge of `line_pulse` is a cycle where `line_pulse` is low and was high at the previous clock edge. On that clock edge the current-line latch loads `line_data`. On every other edge it keeps its value, so changing `line_data` between pulses leaves the outputs unchanged.
- R3: On the same falling edge, the previous-line latch loads the old contents of the current-line latch.
- R4: The first alternation stage loads `alt_in` on a rising edge of `line_pulse`. The second alternation stage loads the first stage on a falling edge.
- R5: While `disp_on` is low, every output reads code 2 (mid level), whatever the data, alternation and window inputs are.
- R6: Output i is `lvl_code[3*i +: 3]` and follows bit i of the latched lines. The codes are 0 = low compensation, 1 = low, 2 = mid, 3 = high, 4 = high compensation, and no code above 4 ever appears. Outside a window, with `disp_on` high, the output is 3 when (current bit XOR `alt_in`) is 1 and 1 otherwise.
- R7: The compensation window is open while `win_a` is high, or while `win_b` and `line_pulse` are both high. `win_b` with `line_pulse` low opens no window.
- R8: Inside a window, with `disp_on` high, compare the new polarity (current bit XOR `alt_in`) with the old polarity (previous bit XOR second alternation stage). If they differ, the output is 4 when the new polarity is 1 and 0 when it is 0. If they are equal, the output is the R6 level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_pulse | input | 1 | Line start pulse, sampled on clk |
| line_data | input | NOUT | Loaded line of display bits |
| alt_in | input | 1 | Frame alternation (polarity) input |
| win_a | input | 1 | Compensation window, direct |
| win_b | input | 1 | Compensation window, qualified by line_pulse |
| disp_on | input | 1 | Display enable; low forces mid level |
| lvl_code | output | 3*NOUT | Per-output level code |

## Verification
The latches are loaded with several patterns: all zeros, all ones, alternating bits, and a mixed word. Each is compared against an independent model of the level table, which tells a wrong bit-to-output mapping apart from a wrong polarity. Line sequences in which each bit keeps its value, flips, or flips back show whether compensation follows the previous line or only the current one. Changing `alt_in` between a line's rising and falling edge shows whether the inversion of the previous line uses the delayed alternation copy. Opening the window with each window input separately, with the line pulse both high and low, shows whether `win_b` is qualified correctly. Toggling `line_data` with no pulse shows whether the latches hold between line edges.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      LV_LOWC  = 3'd0,
      LV_LOW   = 3'd1,
      LV_MID   = 3'd2,
      LV_HIGH  = 3'd3,
      LV_HIGHC = 3'd4
   } lvl_e;

   // Per-output drive level from the latched bits and control state.
   function automatic lvl_e pick_level(
      input logic cur_bit,
      input logic prv_bit,
      input logic alt_now,
      input logic alt_old,
      input logic win,
      input logic show
   );
      logic pol_new, pol_old;
      pol_new = cur_bit ^ alt_now;
      pol_old = prv_bit ^ alt_old;
      if (!show)
         return LV_MID;
      if (win && (pol_new != pol_old))
         return pol_new ? LV_HIGHC : LV_LOWC;
      return pol_new ? LV_HIGH : LV_LOW;
   endfunction

endpackage

// File: rtl/seg_lp_edge.sv
module seg_lp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_in,
   output logic rise_o,
   output logic fall_o
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= pulse_in;
   end

   assign rise_o = pulse_in & ~pulse_q;
   assign fall_o = ~pulse_in & pulse_q;
endmodule

// File: rtl/seg_line_pipe.sv
module seg_line_pipe #(
   parameter int WIDTH = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] cur_q,
   output logic [WIDTH-1:0] prv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         prv_q <= '0;
      end else if (load) begin
         prv_q <= cur_q;
         cur_q <= din;
      end
   end
endmodule

// File: rtl/seg_alt_pipe.sv
module seg_alt_pipe (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   input  logic fall,
   input  logic alt_in,
   output logic alt1_q,
   output logic alt2_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alt1_q <= 1'b0;
         alt2_q <= 1'b0;
      end else begin
         if (rise) alt1_q <= alt_in;
         if (fall) alt2_q <= alt1_q;
      end
   end
endmodule

// File: rtl/seg_level_cell.sv
module seg_level_cell
   import seg_drv_pkg::*;
(
   input  logic              cur_bit,
   input  logic              prv_bit,
   input  logic              alt_now,
   input  logic              alt_old,
   input  logic              win,
   input  logic              show,
   output logic [CODE_W-1:0] code
);
   lvl_e lvl;

   always_comb lvl = pick_level(cur_bit, prv_bit, alt_now, alt_old, win, show);

   assign code = lvl;
endmodule

// File: rtl/seg_level_drive.sv
module seg_level_drive
   import seg_drv_pkg::*;
#(
   parameter int NOUT    = 160,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   line_pulse,
   input  logic [NOUT-1:0]        line_data,
   input  logic                   alt_in,
   input  logic                   win_a,
   input  logic                   win_b,
   input  logic                   disp_on,
   output logic [NOUT*CODE_W-1:0] lvl_code
);
   localparam int OUT_W = NOUT * CODE_W;

   if (NOUT < 1) begin : g_bad_nout
      $error("seg_level_drive: NOUT must be at least 1");
   end

   logic            lp_rise, lp_fall;
   logic [NOUT-1:0] cur_q, prv_q;
   logic            alt1_q, alt2_q;
   logic            win_open;
   logic [OUT_W-1:0] code_c;

   seg_lp_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_in (line_pulse),
      .rise_o   (lp_rise),
      .fall_o   (lp_fall)
   );

   seg_line_pipe #(.WIDTH(NOUT)) u_lines (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (lp_fall),
      .din   (line_data),
      .cur_q (cur_q),
      .prv_q (prv_q)
   );

   seg_alt_pipe u_alt (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (lp_rise),
      .fall   (lp_fall),
      .alt_in (alt_in),
      .alt1_q (alt1_q),
      .alt2_q (alt2_q)
   );

   assign win_open = win_a | (win_b & line_pulse);

   for (genvar i = 0; i < NOUT; i++) begin : g_cell
      seg_level_cell u_cell (
         .cur_bit (cur_q[i]),
         .prv_bit (prv_q[i]),
         .alt_now (alt_in),
         .alt_old (alt2_q),
         .win     (win_open),
         .show    (disp_on),
         .code    (code_c[i*CODE_W +: CODE_W])
      );
   end

   if (REG_OUT) begin : g_out_reg
      logic [OUT_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) code_q <= {NOUT{LV_MID}};
         else        code_q <= code_c;
      end
      assign lvl_code = code_q;
   end else begin : g_out_comb
      assign lvl_code = code_c;
   end
endmodule

// File: rtl/seg_level_drive_chk.sv
module seg_level_drive_chk
   import seg_drv_pkg::*;
#(
   parameter int NOUT    = 160,
   parameter bit REG_OUT = 1'b0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   line_pulse,
   input logic [NOUT-1:0]        line_data,
   input logic                   alt_in,
   input logic                   win_a,
   input logic                   win_b,
   input logic                   disp_on,
   input logic [NOUT*CODE_W-1:0] lvl_code,
   input logic [NOUT-1:0]        cur_q,
   input logic [NOUT-1:0]        prv_q,
   input logic                   alt1_q,
   input logic                   alt2_q
);
   logic lp_d;
   logic fall_s, rise_s;
   logic all_mid, any_comp, any_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_d <= 1'b0;
      else        lp_d <= line_pulse;
   end

   assign fall_s = lp_d & ~line_pulse;
   assign rise_s = ~lp_d & line_pulse;

   always_comb begin
      all_mid  = 1'b1;
      any_comp = 1'b0;
      any_bad  = 1'b0;
      for (int i = 0; i < NOUT; i++) begin
         if (lvl_code[i*CODE_W +: CODE_W] != 3'd2) all_mid = 1'b0;
         if (lvl_code[i*CODE_W +: CODE_W] == 3'd0 ||
             lvl_code[i*CODE_W +: CODE_W] == 3'd4) any_comp = 1'b1;
         if (lvl_code[i*CODE_W +: CODE_W] > 3'd4) any_bad = 1'b1;
      end
   end

   assert_cur_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_s |=> cur_q == $past(line_data));

   assert_cur_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_s |=> $stable(cur_q));

   assert_prv_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fall_s |=> prv_q == $past(cur_q));

   assert_alt1_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_s |=> alt1_q == $past(alt_in));

   assert_alt2_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fall_s |=> alt2_q == $past(alt1_q));

   if (!REG_OUT) begin : g_out_checks
      assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !disp_on |-> all_mid);

      assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !any_bad);

      assert_no_comp_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (disp_on && !win_a && !(win_b && line_pulse)) |-> !any_comp);
   end
endmodule

bind seg_level_drive seg_level_drive_chk #(.NOUT(NOUT), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_pulse (line_pulse),
   .line_data  (line_data),
   .alt_in     (alt_in),
   .win_a      (win_a),
   .win_b      (win_b),
   .disp_on    (disp_on),
   .lvl_code   (lvl_code),
   .cur_q      (cur_q),
   .prv_q      (prv_q),
   .alt1_q     (alt1_q),
   .alt2_q     (alt2_q)
);

// File: tb/seg_level_drive_tb.sv
`timescale 1ns/1ps
module seg_level_drive_tb;
   localparam int N  = 160;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_pulse = 1'b0;
   logic [N-1:0] line_data = '0;
   logic alt_in = 1'b0;
   logic win_a = 1'b0;
   logic win_b = 1'b0;
   logic disp_on = 1'b1;
   logic [N*CW-1:0] lvl_code;

   int checks = 0;
   int errors = 0;

   // bench model state
   logic [N-1:0] m_cur = '0, m_prv = '0;
   logic m_a1 = 1'b0, m_a2 = 1'b0;

   always #4 clk = ~clk;

   seg_level_drive u_dut (
      .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .line_data(line_data),
      .alt_in(alt_in), .win_a(win_a), .win_b(win_b), .disp_on(disp_on),
      .lvl_code(lvl_code)
   );

   function automatic logic [CW-1:0] ref_code(logic q, logic qp, logic a, logic a2,
                                              logic w, logic on);
      logic pn, po;
      pn = q ^ a;
      po = qp ^ a2;
      if (!on) return 3'd2;
      if (w && pn != po) return pn ? 3'd4 : 3'd0;
      return pn ? 3'd3 : 3'd1;
   endfunction

   function automatic logic [N*CW-1:0] ref_vec();
      logic [N*CW-1:0] v;
      logic w;
      w = win_a | (win_b & line_pulse);
      for (int i = 0; i < N; i++)
         v[i*CW +: CW] = ref_code(m_cur[i], m_prv[i], alt_in, m_a2, w, disp_on);
      return v;
   endfunction

   // one clock: drive at negedge beforehand, sample 1 ns after posedge
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag);
      logic [N*CW-1:0] e;
      e = ref_vec();
      checks++;
      if (lvl_code !== e) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, lvl_code, e);
      end
   endtask

   task automatic set_pulse(logic v);
      @(negedge clk);
      if (v && !line_pulse) m_a1 = alt_in;
      if (!v && line_pulse) begin
         m_prv = m_cur;
         m_cur = line_data;
         m_a2  = m_a1;
      end
      line_pulse = v;
      tick();
   endtask

   task automatic load_line(logic [N-1:0] d, logic a);
      @(negedge clk);
      line_data = d;
      alt_in = a;
      set_pulse(1'b1);
      set_pulse(1'b0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      m_cur = '0; m_prv = '0; m_a1 = 1'b0; m_a2 = 1'b0;
      line_pulse = 1'b0; line_data = '0; alt_in = 1'b0;
      win_a = 1'b0; win_b = 1'b0; disp_on = 1'b1;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      checks++;
      if (lvl_code !== {N{3'd1}}) begin
         errors++;
         $display("FAIL R1 actual=%h expected=%h", lvl_code, {N{3'd1}});
      end
   endtask

   task automatic t_patterns();
      logic [N-1:0] pats [4];
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = {(N/2){2'b10}};
      pats[3] = {5{32'hC3A5_1E69}};
      foreach (pats[k]) begin
         load_line(pats[k], 1'b0);
         check("R2_R6 pattern");
      end
      load_line(pats[2], 1'b1);
      check("R6 alt inversion");
   endtask

   task automatic t_hold();
      load_line({5{32'h0F0F_3355}}, 1'b0);
      @(negedge clk);
      line_data = ~line_data;
      tick(); tick();
      check("R2 hold without pulse");
   endtask

   task automatic t_window_a();
      load_line({5{32'h1234_5678}}, 1'b0);
      load_line({5{32'h9ABC_DEF0}}, 1'b0);
      @(negedge clk); win_a = 1'b1; #1;
      check("R8 window a compensation");
      @(negedge clk); alt_in = 1'b1; #1;
      check("R8 window a with alt high");
      @(negedge clk); win_a = 1'b0; alt_in = 1'b0; #1;
      check("R7 window closed");
   endtask

   task automatic t_prev_line();
      load_line('1, 1'b0);
      load_line('1, 1'b0);
      @(negedge clk); win_a = 1'b1; #1;
      check("R3 unchanged line no comp");
      @(negedge clk); win_a = 1'b0;
      load_line({(N/2){2'b01}}, 1'b0);
      @(negedge clk); win_a = 1'b1; #1;
      check("R3 previous line feeds comp");
      @(negedge clk); win_a = 1'b0; #1;
   endtask

   task automatic t_window_b();
      load_line({5{32'hFFFF_0000}}, 1'b0);
      load_line({5{32'hF0F0_F0F0}}, 1'b0);
      @(negedge clk); win_b = 1'b1; #1;
      check("R7 win_b with pulse low");
      set_pulse(1'b1);
      check("R7 win_b with pulse high");
      @(negedge clk); win_b = 1'b0;
      set_pulse(1'b0);
      check("R2 load after win_b");
   endtask

   task automatic t_alt_pipe();
      // alt changes between rise and fall: delayed copy must take the rise value
      load_line({5{32'hAAAA_5555}}, 1'b0);
      @(negedge clk); line_data = {5{32'h5555_AAAA}}; alt_in = 1'b1;
      set_pulse(1'b1);
      @(negedge clk); alt_in = 1'b0;
      set_pulse(1'b0);
      @(negedge clk); alt_in = 1'b1; win_a = 1'b1; #1;
      check("R4 delayed alt in window");
      @(negedge clk); alt_in = 1'b0; #1;
      check("R4 delayed alt, alt low");
      load_line({5{32'h5555_AAAA}}, 1'b0);
      check("R4 second stage after fall");
      @(negedge clk); win_a = 1'b0; #1;
   endtask

   task automatic t_blank();
      load_line({5{32'h0123_4567}}, 1'b1);
      @(negedge clk); disp_on = 1'b0; win_a = 1'b1; win_b = 1'b1; #1;
      check("R5 blank with windows");
      @(negedge clk); alt_in = 1'b0; #1;
      check("R5 blank alt toggled");
      @(negedge clk); disp_on = 1'b1; win_a = 1'b0; win_b = 1'b0; #1;
      check("R6 after blank");
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_patterns();
            t_hold();
            t_window_a();
            t_prev_line();
            t_window_b();
            t_alt_pipe();
            t_blank();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule